// File: doc/BRIEF.md
# Pen-Down Scan Trigger Scheduler

This block turns the level-sensitive pen-down interrupt of a resistive touch front end into a paced series of single-cycle scan-start pulses. The interrupt line is a level detector on one of the panel plates, so it becomes invalid whenever the converter switches channels. The block therefore masks it from the moment a scan is requested, and unmasks it only when the panel is idle and settled.

After a scan completes, an internal interval timer is reloaded with the nominal period minus the measured scan time, so that scans start on a steady cadence. When the pen lifts, the block keeps polling for a bounded number of periods. Only after a minimum number of those polls does it listen to the interrupt again, in the half of each period that has no scan. Once the poll budget is spent it parks in an idle state with the interrupt open and the timer stopped, which saves power. A level arm input switches the whole scheduler on and off. The timer counts ticks of a one-microsecond clock enable, and the raw interrupt passes through a two-flop synchronizer.

Top module: `pen_trig_sched`

## Requirements
- R1: After reset `irq_mask` is 1 and `scan_start` is 0, and while `arm` is low a high `pen_irq` causes no scan_start.
- R2: With `arm` high and the block off, `irq_mask` falls to 0 on the next clock edge (idle state), and no scan_start follows while `pen_irq` stays low.
- R3: A high `pen_irq` (after the two-flop synchronizer) while `irq_mask` is 0 and `arm` is high raises `irq_mask` and gives exactly one scan_start request.
- R4: `scan_start` is one cycle wide. No further pulse is issued until `scan_done` has been seen for the previous one, and a request made while a scan is outstanding is held and issued after `scan_done`.
- R5: `scan_done` reloads the timer with INTERVAL_US minus `scan_time_us` ticks, or with 1 tick when the scan time is INTERVAL_US or more. A tick is a clock edge with `tick_us` high.
- R6: For poll numbers 1 to MIN_POLLS-1 after release, `irq_mask` stays 1 throughout, and the next scan_start comes one full INTERVAL_US after the reload expires.
- R7: For poll numbers MIN_POLLS to MIN_POLLS+EXT_POLLS, `irq_mask` is 0 during that extra interval and is 1 again when the scan_start is issued.
- R8: When the reload expires after MIN_POLLS+EXT_POLLS polls, the block goes idle: `irq_mask` is 0 and no further scan_start is issued without a new interrupt.
- R9: An interrupt taken in an open poll window restarts the sequence with a cleared poll count, so the next poll again waits the reload plus one full interval.
- R10: `arm` low forces the off state on the next edge: `irq_mask` is 1, the timer is stopped, no scan_start is issued, and a `scan_done` while off starts no timer.
- R11: A timer expiry while idle produces a one-cycle `stray_expiry` pulse, issues no scan_start, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-microsecond clock enable for the interval timer |
| arm | input | 1 | Level enable; low holds the scheduler off |
| pen_irq | input | 1 | Raw pen-down level, active high, asynchronous |
| scan_done | input | 1 | One-cycle pulse when the requested scan has finished |
| scan_time_us | input | TW | Measured duration of the last scan in ticks |
| scan_start | output | 1 | One-cycle request to start a scan |
| irq_mask | output | 1 | 1 while the pen interrupt is ignored |
| stray_expiry | output | 1 | One-cycle flag for a timer expiry in the idle state |

## Verification
A pen tap that is released at once is swept across three tick rates and five scan times, including a scan time of zero, one equal to the interval and one longer than it. The tick count from each scan_done to the next scan_start separates a correct reload (R5) from a missing subtraction or a missing saturation. Whether the mask opened inside each poll interval tells the masked polls from the open ones. A pen that is held down shows that an open window re-triggers at once and that the poll count is cleared. Disarming in the middle of a sequence, re-arming while a scan is still outstanding, and a late scan_done arriving in the idle state reach the held trigger (R4), the stray-expiry flag (R11) and the off-state behaviour (R10).

// File: rtl/pts_pkg.sv
package pts_pkg;

  // Scheduler states. OFF: disarmed. IDLE: armed, interrupt open, timer stopped.
  // HOLD: poll interval with the interrupt masked. OPEN: poll interval with the
  // interrupt open. SCAN: a scan was requested, interrupt masked.
  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_IDLE = 3'd1,
    PS_HOLD = 3'd2,
    PS_OPEN = 3'd3,
    PS_SCAN = 3'd4
  } pts_state_e;

  // Interrupt is ignored in every state except IDLE and OPEN.
  function automatic logic masked_in(pts_state_e s);
    return !(s == PS_IDLE || s == PS_OPEN);
  endfunction

  // Delay after a scan: the remainder of the interval, never less than one tick.
  function automatic int unsigned rearm_ticks(int unsigned interval, int unsigned used);
    if (used >= interval) return 1;
    return interval - used;
  endfunction

endpackage

// File: rtl/pts_sync.sv
module pts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr_q <= '0;
        else        sr_q <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/pts_timer.sv
module pts_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          stop,
  output logic          expire
);
  logic [TW-1:0] cnt_q;
  logic          run_q;

  // Fires on the tick that would take the count from one to zero.
  assign expire = run_q && tick && (cnt_q == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (expire) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end
endmodule

// File: rtl/pts_trig_gate.sv
module pts_trig_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clear,
  input  logic done,
  output logic start,
  output logic busy
);
  logic pend_q, busy_q, start_q, fire;

  // A request waits while a scan is outstanding; clear drops it.
  assign fire = (req || pend_q) && !busy_q && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= fire;
      pend_q  <= clear ? 1'b0 : ((req || pend_q) && !fire);
      if (fire)      busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
    end
  end

  assign start = start_q;
  assign busy  = busy_q;
endmodule

// File: rtl/pts_sched.sv
module pts_sched
  import pts_pkg::*;
#(
  parameter int INTERVAL = 10000,
  parameter int MIN_POLLS = 3,
  parameter int TOTAL = 6,
  parameter int TW = 16,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          pen,
  input  logic          expire,
  input  logic          done,
  input  logic          busy,
  input  logic [TW-1:0] scan_time,
  output pts_state_e    state,
  output logic [CW-1:0] poll_cnt,
  output logic          irq_fire,
  output logic          trig_req,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tmr_stop,
  output logic          mask,
  output logic          stray
);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_POLLS);
  localparam logic [CW-1:0] TOT_C = CW'(TOTAL);
  localparam logic [TW-1:0] IVL_C = TW'(INTERVAL);

  pts_state_e    st_q, st_n;
  logic [CW-1:0] poll_q, poll_n;
  logic          stray_q, stray_n;
  logic [CW-1:0] poll_inc;

  assign poll_inc = poll_q + CW'(1);
  assign mask     = masked_in(st_q);
  assign irq_fire = arm && pen && (st_q != PS_OFF) && !mask;

  always_comb begin
    st_n     = st_q;
    poll_n   = poll_q;
    trig_req = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = IVL_C;
    tmr_stop = 1'b0;
    stray_n  = 1'b0;
    if (!arm) begin
      st_n     = PS_OFF;
      tmr_stop = 1'b1;
    end else if (st_q == PS_OFF) begin
      st_n = PS_IDLE;
    end else if (irq_fire) begin
      st_n     = PS_SCAN;
      poll_n   = '0;
      trig_req = 1'b1;
      tmr_stop = 1'b1;
    end else begin
      if (done && busy) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(rearm_ticks(INTERVAL, int'(scan_time)));
      end
      if (expire) begin
        unique case (st_q)
          PS_SCAN: begin
            if (poll_q < TOT_C) begin
              poll_n   = poll_inc;
              tmr_load = 1'b1;
              tmr_val  = IVL_C;
              st_n     = (poll_inc >= MIN_C) ? PS_OPEN : PS_HOLD;
            end else begin
              st_n = PS_IDLE;
            end
          end
          PS_HOLD, PS_OPEN: begin
            st_n     = PS_SCAN;
            trig_req = 1'b1;
          end
          PS_IDLE: stray_n = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_OFF;
      poll_q  <= '0;
      stray_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      poll_q  <= poll_n;
      stray_q <= stray_n;
    end
  end

  assign state    = st_q;
  assign poll_cnt = poll_q;
  assign stray    = stray_q;
endmodule

// File: rtl/pen_trig_sched.sv
module pen_trig_sched
  import pts_pkg::*;
#(
  parameter int INTERVAL_US = 10000,
  parameter int MIN_POLLS = 3,
  parameter int EXT_POLLS = 3,
  parameter int TW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic          arm,
  input  logic          pen_irq,
  input  logic          scan_done,
  input  logic [TW-1:0] scan_time_us,
  output logic          scan_start,
  output logic          irq_mask,
  output logic          stray_expiry
);
  localparam int TOTAL_POLLS = MIN_POLLS + EXT_POLLS;
  localparam int CW = $clog2(TOTAL_POLLS + 1);

  logic          pen_s;
  logic          tmr_expire, tmr_load, tmr_stop;
  logic [TW-1:0] tmr_val;
  logic          trig_req, busy, irq_fire;
  logic [CW-1:0] poll_cnt;
  pts_state_e    state;

  pts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pen_irq), .q(pen_s)
  );

  pts_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .load(tmr_load),
    .load_val(tmr_val), .stop(tmr_stop), .expire(tmr_expire)
  );

  pts_sched #(
    .INTERVAL(INTERVAL_US), .MIN_POLLS(MIN_POLLS), .TOTAL(TOTAL_POLLS),
    .TW(TW), .CW(CW)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .arm(arm), .pen(pen_s), .expire(tmr_expire),
    .done(scan_done), .busy(busy), .scan_time(scan_time_us),
    .state(state), .poll_cnt(poll_cnt), .irq_fire(irq_fire),
    .trig_req(trig_req), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .tmr_stop(tmr_stop), .mask(irq_mask), .stray(stray_expiry)
  );

  pts_trig_gate u_gate (
    .clk(clk), .rst_n(rst_n), .req(trig_req), .clear(!arm),
    .done(scan_done), .start(scan_start), .busy(busy)
  );
endmodule

// File: rtl/pen_trig_sched_chk.sv
module pen_trig_sched_chk
  import pts_pkg::*;
#(
  parameter int TOTAL = 6,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          scan_done,
  input logic          scan_start,
  input logic          irq_mask,
  input logic          stray_expiry,
  input logic          irq_fire,
  input pts_state_e    state,
  input logic [CW-1:0] poll_cnt
);
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         outst_q <= 1'b0;
    else if (scan_start) outst_q <= 1'b1;
    else if (scan_done)  outst_q <= 1'b0;

  a_r1_off_masked: assert property (@(posedge clk) disable iff (!rst_n)
    state == PS_OFF |-> irq_mask && !scan_start);

  a_r2_arm_opens: assert property (@(posedge clk) disable iff (!rst_n)
    arm && state == PS_OFF |=> !irq_mask);

  a_r3_fire_masks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fire |=> irq_mask);

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> !scan_start);

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> !outst_q);

  a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= CW'(TOTAL));

  a_r10_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> irq_mask && !scan_start);

  a_r11_stray_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stray_expiry |-> !irq_mask && !scan_start);
endmodule

bind pen_trig_sched pen_trig_sched_chk #(.TOTAL(TOTAL_POLLS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .scan_done(scan_done),
  .scan_start(scan_start), .irq_mask(irq_mask), .stray_expiry(stray_expiry),
  .irq_fire(irq_fire), .state(state), .poll_cnt(poll_cnt)
);

// File: tb/pen_trig_sched_tb_top.sv
module pen_trig_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IV = 20;
  localparam int MINP = 3;
  localparam int EXTP = 3;
  localparam int TOT = MINP + EXTP;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0;
  logic tick_us = 0, arm = 0, pen_irq = 0, scan_done = 0;
  logic [TW-1:0] scan_time_us = '0;
  logic scan_start, irq_mask, stray_expiry;

  int n_chk = 0, n_err = 0;
  int div = 1, tick_ph = 0;
  int tick_total = 0, n_start = 0, n_stray = 0;
  bit low_seen = 0;

  pen_trig_sched #(.INTERVAL_US(IV), .MIN_POLLS(MINP), .EXT_POLLS(EXTP), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .arm(arm), .pen_irq(pen_irq),
    .scan_done(scan_done), .scan_time_us(scan_time_us), .scan_start(scan_start),
    .irq_mask(irq_mask), .stray_expiry(stray_expiry)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_us = (tick_ph == 0);
    tick_ph = (tick_ph >= div - 1) ? 0 : tick_ph + 1;
    if (scan_start) n_start++;
    if (stray_expiry) n_stray++;
    if (!irq_mask) low_seen = 1;
  end

  always @(posedge clk) if (tick_us) tick_total++;

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int reload(input int st);
    return (st >= IV) ? 1 : IV - st;
  endfunction

  task automatic wait_start(input int limit, output bit found, output int at_tick);
    int s0 = n_start;
    found = 0; at_tick = 0;
    for (int i = 0; i < limit; i++) begin
      step();
      if (n_start != s0) begin found = 1; at_tick = tick_total; break; end
    end
  endtask

  task automatic give_done(output int t0);
    scan_done = 1; step(); scan_done = 0;
    t0 = tick_total; low_seen = 0;
  endtask

  task automatic go_idle();
    pen_irq = 0; arm = 0; step(); step(); arm = 1; step(); step();
  endtask

  task automatic release_session(input int d, input int st);
    bit f; int t0, tt, n, s0;
    div = d; scan_time_us = TW'(st); n = reload(st);
    go_idle();
    s0 = n_start;
    pen_irq = 1;
    wait_start(20, f, tt);
    chk("R3", "trigger on pen", f, 1);
    pen_irq = 0;
    repeat (6) step();
    chk("R3", "mask after fire", irq_mask, 1);
    chk("R3", "single trigger", n_start - s0, 1);
    for (int k = 1; k <= TOT; k++) begin
      repeat (3) step();
      give_done(t0);
      wait_start((n + IV) * d + 20, f, tt);
      chk(k < MINP ? "R6" : "R7", "poll trigger found", f, 1);
      chk("R5", "ticks done->start", tt - t0, n + IV);
      chk(k < MINP ? "R6" : "R7", "mask opened in poll", low_seen, (k >= MINP) ? 1 : 0);
      chk("R7", "mask at trigger", irq_mask, 1);
    end
    repeat (3) step();
    give_done(t0);
    while (tick_total - t0 < n) step();
    repeat (3) step();
    chk("R8", "idle mask", irq_mask, 0);
    s0 = n_start;
    repeat (3 * IV * d) step();
    chk("R8", "no trigger in idle", n_start - s0, 0);
  endtask

  initial begin
    bit f; int t0, tt, n, s0, r0;
    repeat (3) step();
    chk("R1", "mask in reset", irq_mask, 1);
    rst_n = 1;
    pen_irq = 1;
    s0 = n_start;
    repeat (40) step();
    chk("R1", "mask while off", irq_mask, 1);
    chk("R1", "no trigger while off", n_start - s0, 0);
    pen_irq = 0; step(); step();
    arm = 1; step();
    chk("R2", "mask after arm", irq_mask, 0);
    repeat (20) step();
    chk("R2", "no trigger when idle", n_start - s0, 0);

    for (int d = 1; d <= 3; d++) begin
      release_session(d, 0);
      release_session(d, 7);
      release_session(d, 19);
      release_session(d, IV);
      release_session(d, 25);
    end

    // R9: pen held down re-triggers in the first open window, then count restarts
    div = 1; scan_time_us = 5; n = reload(5);
    go_idle();
    pen_irq = 1;
    wait_start(20, f, tt);
    chk("R3", "held pen trigger", f, 1);
    for (int k = 1; k < MINP; k++) begin
      repeat (3) step();
      give_done(t0);
      wait_start(n + IV + 20, f, tt);
      chk("R6", "held poll ticks", tt - t0, n + IV);
    end
    repeat (3) step();
    give_done(t0);
    wait_start(n + IV + 20, f, tt);
    chk("R9", "early retrigger", (tt - t0 >= n && tt - t0 <= n + 1) ? 1 : 0, 1);
    pen_irq = 0;
    repeat (3) step();
    give_done(t0);
    wait_start(n + IV + 20, f, tt);
    chk("R9", "count cleared, full wait", tt - t0, n + IV);
    chk("R9", "mask stayed closed", low_seen, 0);

    // R10: disarm mid-sequence, late done while off
    arm = 0; step();
    chk("R10", "mask on disarm", irq_mask, 1);
    s0 = n_start; r0 = n_stray;
    give_done(t0);
    repeat (4 * IV) step();
    chk("R10", "no trigger while off", n_start - s0, 0);
    chk("R10", "no timer while off", n_stray - r0, 0);
    arm = 1; step();
    chk("R2", "re-arm opens", irq_mask, 0);
    repeat (2 * IV) step();
    chk("R10", "no trigger after re-arm", n_start - s0, 0);

    // R11: scan outstanding across disarm, done lands in idle
    go_idle();
    pen_irq = 1;
    wait_start(20, f, tt);
    pen_irq = 0;
    arm = 0; step(); arm = 1; step();
    chk("R2", "idle with scan outstanding", irq_mask, 0);
    s0 = n_start; r0 = n_stray;
    give_done(t0);
    while (tick_total - t0 < n) step();
    repeat (3) step();
    chk("R11", "stray pulse", n_stray - r0, 1);
    chk("R11", "no trigger on stray", n_start - s0, 0);
    chk("R11", "still idle", irq_mask, 0);

    // R4: interrupt taken while a scan is outstanding is held until done
    go_idle();
    pen_irq = 1;
    wait_start(20, f, tt);
    pen_irq = 0;
    arm = 0; step(); arm = 1; step();
    pen_irq = 1;
    s0 = n_start;
    repeat (20) step();
    chk("R3", "mask on held fire", irq_mask, 1);
    chk("R4", "no trigger while busy", n_start - s0, 0);
    pen_irq = 0;
    give_done(t0);
    wait_start(10, f, tt);
    chk("R4", "held trigger issued", f, 1);
    chk("R4", "exactly one", n_start - s0, 1);
    give_done(t0);
    arm = 0; repeat (4) step();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule